// File: doc/BRIEF.md
# Dual-Parity Stripe Syndrome Engine

This block computes the two redundancy words of a dual-parity disk stripe as a stream. At one byte offset within the stripe, the data members arrive one 64-bit word at a time. They come highest member first and go down to member 0. The engine keeps two running words. The first is a plain XOR parity (P). The second is a Reed-Solomon style syndrome (Q) over GF(2^8), built by Horner evaluation: each new word is added to the previous syndrome after that syndrome has been doubled in the field. Every byte lane of the word is processed on its own, so one word carries eight independent byte columns of the page. A caller walks the page in 8-byte steps and sends one stripe's worth of words per step.

Words enter through a valid/ready channel. A flag marks the word of member 0. Once that word has been absorbed, the finished P and Q words are offered on a second valid/ready channel. They are held there until they are taken. No new input is accepted while a result is waiting.

Top module: `pq_syndrome_engine`

## Requirements
- R1: After a synchronous active-high reset, `res_valid` is 0, `word_ready` is 1, and both `res_p` and `res_q` are 0.
- R2: A stripe holds between 2 and MEMBERS-2 data words. Of a stripe of MEMBERS members, member MEMBERS-2 stores P and member MEMBERS-1 stores Q. The first word accepted in a stripe loads both running words directly, discarding any value left from an earlier stripe.
- R3: `res_p` equals the bytewise XOR of every data word accepted in the stripe.
- R4: The syndrome is built by Horner's rule. It starts as the first (highest-member) word, and for each following word W it becomes double(Q) XOR W. As a result, feeding the same words in a different order changes `res_q` but not `res_p`.
- R5: Doubling acts on each byte separately. The byte is shifted left by one bit, and if its bit 7 was 1 before the shift, the result is XORed with 8'h1d. Nothing carries from one byte (bits 8k+7..8k) into the next.
- R6: `res_valid` rises on the clock edge that accepts the word flagged `word_last`, and stays low after the edge that accepts any other word. `word_ready` is low whenever `res_valid` is high.
- R7: While `res_valid` is high and `res_take` is low, `res_valid`, `res_p` and `res_q` hold their values.
- R8: On the edge where `res_valid` and `res_take` are both high, `res_valid` falls and `word_ready` returns to 1. A fresh stripe can then be accepted from the next cycle onward.
- R9: Cycles with `word_valid` low leave the running words unchanged, whatever is on `word_data`.
- R10: A word presented while `word_ready` is low is not absorbed. It changes neither the pending result nor the following stripe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | A data word is presented |
| word_ready | output | 1 | The engine can absorb a word this cycle |
| word_data | input | LANES*8 | Data word of one member |
| word_last | input | 1 | This word belongs to member 0 and closes the stripe |
| res_valid | output | 1 | Finished P and Q are presented |
| res_take | input | 1 | Consumer accepts P and Q |
| res_p | output | LANES*8 | XOR parity of the stripe |
| res_q | output | LANES*8 | GF(2^8) syndrome of the stripe |

## Verification
The stripes use several kinds of word pattern, and each exposes a different fault. Words with every byte's top bit set tell a correct 0x1d reduction apart from a bare shift. A word with only the bottom byte at 0x80 exposes any carry into the neighbouring lane. Mixed multi-word stripes exercise the whole Horner chain. Reversing the word order of a stripe must alter Q while leaving P the same, which separates a true order-dependent syndrome from a second XOR. Directed runs add idle gaps, a held result with input still pressing, and back-to-back stripes, which expose leakage from a previous stripe.

// File: rtl/pq_pkg.sv
package pq_pkg;
   localparam int BYTE_W = 8;

   // Field doubling of one byte with a chosen reduction constant
   function automatic logic [BYTE_W-1:0] gf_double_byte(
      input logic [BYTE_W-1:0] b,
      input logic [BYTE_W-1:0] poly
   );
      logic [BYTE_W-1:0] shifted;
      shifted = {b[BYTE_W-2:0], 1'b0};
      return b[BYTE_W-1] ? (shifted ^ poly) : shifted;
   endfunction
endpackage

// File: rtl/pq_lane_double.sv
module pq_lane_double #(
   parameter int          LANES = 8,
   parameter logic [7:0]  POLY  = 8'h1d,
   localparam int         W     = LANES * pq_pkg::BYTE_W
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         assign dout[ln*pq_pkg::BYTE_W +: pq_pkg::BYTE_W] =
            pq_pkg::gf_double_byte(din[ln*pq_pkg::BYTE_W +: pq_pkg::BYTE_W], POLY);
      end
   endgenerate
endmodule

// File: rtl/pq_accum.sv
module pq_accum #(
   parameter int          LANES = 8,
   parameter logic [7:0]  POLY  = 8'h1d,
   localparam int         W     = LANES * pq_pkg::BYTE_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         absorb,
   input  logic         load_first,
   input  logic [W-1:0] din,
   output logic [W-1:0] p_acc,
   output logic [W-1:0] q_acc
);
   logic [W-1:0] q_dbl;

   pq_lane_double #(.LANES(LANES), .POLY(POLY)) u_dbl (
      .din  (q_acc),
      .dout (q_dbl)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         p_acc <= '0;
         q_acc <= '0;
      end else if (absorb) begin
         if (load_first) begin
            p_acc <= din;
            q_acc <= din;
         end else begin
            p_acc <= p_acc ^ din;
            q_acc <= q_dbl ^ din;
         end
      end
   end
endmodule

// File: rtl/pq_stripe_ctrl.sv
module pq_stripe_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic word_valid,
   input  logic word_last,
   input  logic res_take,
   output logic word_ready,
   output logic absorb,
   output logic load_first,
   output logic res_valid
);
   logic first_q;

   assign word_ready = ~res_valid;
   assign absorb     = word_valid & word_ready;
   assign load_first = first_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         first_q   <= 1'b1;
         res_valid <= 1'b0;
      end else begin
         if (absorb) begin
            first_q <= word_last;
            if (word_last) res_valid <= 1'b1;
         end
         if (res_valid && res_take) res_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pq_syndrome_engine.sv
module pq_syndrome_engine #(
   parameter int          MEMBERS = 16,
   parameter int          LANES   = 8,
   parameter logic [7:0]  POLY    = 8'h1d,
   localparam int         W       = LANES * pq_pkg::BYTE_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         word_valid,
   output logic         word_ready,
   input  logic [W-1:0] word_data,
   input  logic         word_last,
   output logic         res_valid,
   input  logic         res_take,
   output logic [W-1:0] res_p,
   output logic [W-1:0] res_q
);
   generate
      if (MEMBERS < 4) begin : g_bad_members
         $error("MEMBERS must be at least 4");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
   endgenerate

   logic absorb;
   logic load_first;

   pq_stripe_ctrl u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .word_valid (word_valid),
      .word_last  (word_last),
      .res_take   (res_take),
      .word_ready (word_ready),
      .absorb     (absorb),
      .load_first (load_first),
      .res_valid  (res_valid)
   );

   pq_accum #(.LANES(LANES), .POLY(POLY)) u_acc (
      .clk        (clk),
      .rst        (rst),
      .absorb     (absorb),
      .load_first (load_first),
      .din        (word_data),
      .p_acc      (res_p),
      .q_acc      (res_q)
   );
endmodule

// File: rtl/pq_syndrome_engine_chk.sv
module pq_syndrome_engine_chk #(
   parameter int MEMBERS = 16,
   parameter int W       = 64,
   localparam int DATA_N = MEMBERS - 2,
   localparam int CNT_W  = $clog2(MEMBERS) + 1
) (
   input logic         clk,
   input logic         rst,
   input logic         word_valid,
   input logic         word_ready,
   input logic         word_last,
   input logic         res_valid,
   input logic         res_take,
   input logic [W-1:0] res_p,
   input logic [W-1:0] res_q
);
   logic             rst_q;
   logic [CNT_W-1:0] seen;
   logic             acc_w;

   assign acc_w = word_valid && word_ready;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) seen <= '0;
      else if (acc_w) seen <= word_last ? '0 : seen + 1'b1;
   end

   // R1: reset state observed on the first cycle after reset is released
   always_ff @(posedge clk) begin
      if (rst_q && !rst) begin
         p_reset_state_r1: assert (!res_valid && word_ready && res_p == '0 && res_q == '0);
      end
   end

   p_stripe_max_r2: assert property (@(posedge clk) disable iff (rst)
      acc_w |-> (seen < CNT_W'(DATA_N)));

   p_stripe_min_r2: assert property (@(posedge clk) disable iff (rst)
      (acc_w && word_last) |-> (seen != '0));

   p_done_rise_r6: assert property (@(posedge clk) disable iff (rst)
      (acc_w && word_last) |=> res_valid);

   p_no_early_r6: assert property (@(posedge clk) disable iff (rst)
      (acc_w && !word_last && !res_valid) |=> !res_valid);

   p_ready_gated_r6: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> !word_ready);

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_take) |=> (res_valid && $stable(res_p) && $stable(res_q)));

   p_release_r8: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_take) |=> (!res_valid && word_ready));

   p_idle_r9: assert property (@(posedge clk) disable iff (rst)
      (!word_valid && !res_valid) |=> ($stable(res_p) && $stable(res_q)));
endmodule

bind pq_syndrome_engine pq_syndrome_engine_chk #(.MEMBERS(MEMBERS), .W(W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .word_valid (word_valid),
   .word_ready (word_ready),
   .word_last  (word_last),
   .res_valid  (res_valid),
   .res_take   (res_take),
   .res_p      (res_p),
   .res_q      (res_q)
);

// File: tb/pq_syndrome_engine_tb.sv
`timescale 1ns/1ps
module pq_syndrome_engine_tb_top;
   localparam int W    = 64;
   localparam int NV   = 6;
   localparam int MAXW = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         word_valid = 1'b0;
   logic         word_ready;
   logic [W-1:0] word_data = '0;
   logic         word_last = 1'b0;
   logic         res_valid;
   logic         res_take = 1'b0;
   logic [W-1:0] res_p;
   logic [W-1:0] res_q;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pq_syndrome_engine #(.MEMBERS(16), .LANES(8)) dut_i (
      .clk(clk), .rst(rst),
      .word_valid(word_valid), .word_ready(word_ready),
      .word_data(word_data), .word_last(word_last),
      .res_valid(res_valid), .res_take(res_take),
      .res_p(res_p), .res_q(res_q)
   );

   localparam logic [W-1:0] VW [NV][MAXW] = '{
      '{64'h0101010101010101, 64'h0202020202020202, 64'h0, 64'h0},
      '{64'h8080808080808080, 64'h0000000000000000, 64'h0, 64'h0},
      '{64'hff00ff00ff00ff00, 64'h0123456789abcdef, 64'hfedcba9876543210, 64'h0},
      '{64'hc3a5_5a3c_9966_0ff0, 64'h8001_4002_2004_1008, 64'hdead_beef_cafe_f00d, 64'h7777_8888_9999_aaaa},
      '{64'hfedcba9876543210, 64'h0123456789abcdef, 64'hff00ff00ff00ff00, 64'h0},
      '{64'h0000000000000080, 64'h0000000000000000, 64'h0, 64'h0}
   };
   localparam int VN [NV] = '{2, 2, 3, 4, 3, 2};

   function automatic logic [W-1:0] dbl(input logic [W-1:0] x);
      logic [W-1:0] r;
      for (int k = 0; k < 8; k++) begin
         logic [7:0] b;
         b = x[8*k +: 8];
         r[8*k +: 8] = (b << 1) ^ (b[7] ? 8'h1d : 8'h00);
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [W-1:0] d, input bit last);
      @(negedge clk);
      word_valid = 1'b1; word_data = d; word_last = last;
      while (!word_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      word_valid = 1'b0; word_last = 1'b0; word_data = 64'h5a5a_a5a5_3c3c_c3c3;
   endtask

   task automatic collect(input logic [W-1:0] ep, input logic [W-1:0] eq, input string tag);
      int waitc = 0;
      while (!res_valid && waitc < 20) begin @(negedge clk); waitc++; end
      check(res_valid, {tag, " R6 res_valid"}, W'(res_valid), 1);
      check(res_p == ep, {tag, " R3 P"}, res_p, ep);
      check(res_q == eq, {tag, " R4/R5 Q"}, res_q, eq);
      res_take = 1'b1;
      @(posedge clk);
      @(negedge clk);
      res_take = 1'b0;
      check(!res_valid && word_ready, {tag, " R8 release"}, W'({res_valid, word_ready}), W'(2'b01));
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ep, eq, rp, rq;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!res_valid, "R1 res_valid", W'(res_valid), 0);
      check(word_ready, "R1 word_ready", W'(word_ready), 1);
      check(res_p == '0 && res_q == '0, "R1 acc", res_p | res_q, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         ep = VW[v][0]; eq = VW[v][0];
         for (int i = 1; i < VN[v]; i++) begin
            ep = ep ^ VW[v][i];
            eq = dbl(eq) ^ VW[v][i];
         end
         for (int i = 0; i < VN[v]; i++) begin
            send(VW[v][i], i == VN[v] - 1);
            if (i != VN[v] - 1)
               check(!res_valid, $sformatf("vec%0d R6 early", v), W'(res_valid), 0);
         end
         collect(ep, eq, $sformatf("vec%0d", v));
         if (v == 1) check(eq == 64'h1d1d1d1d1d1d1d1d, "R5 reduce model", eq, 64'h1d1d1d1d1d1d1d1d);
         if (v == 5) check(eq == 64'h000000000000001d, "R5 no carry model", eq, 64'h1d);
      end
      // R4: vec2 and vec4 are reversals: same P, different Q (model sanity)
      check(dbl(dbl(64'hff00ff00ff00ff00)) != dbl(dbl(64'hfedcba9876543210)), "R4 order model", 0, 1);

      // R9: idle gaps with noise on the data bus
      ep = 64'h1111_2222_3333_4444 ^ 64'h0f0f_0f0f_0f0f_0f0f ^ 64'h8888_0000_8888_0000;
      eq = dbl(dbl(64'h1111_2222_3333_4444) ^ 64'h0f0f_0f0f_0f0f_0f0f) ^ 64'h8888_0000_8888_0000;
      send(64'h1111_2222_3333_4444, 1'b0);
      repeat (3) @(negedge clk);
      send(64'h0f0f_0f0f_0f0f_0f0f, 1'b0);
      @(negedge clk);
      send(64'h8888_0000_8888_0000, 1'b1);
      collect(ep, eq, "R9 gaps");

      // R7/R10: hold with input pressing, then R8 back-to-back stripe
      send(64'hAAAA_5555_AAAA_5555, 1'b0);
      send(64'h8181_8181_8181_8181, 1'b1);
      @(negedge clk);
      rp = res_p; rq = res_q;
      word_valid = 1'b1; word_data = 64'hffff_ffff_ffff_ffff; word_last = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check(res_valid && res_p == rp && res_q == rq, "R7 hold", res_q, rq);
         check(!word_ready, "R10 ready low", W'(word_ready), 0);
      end
      word_valid = 1'b0; word_last = 1'b0;
      ep = 64'hAAAA_5555_AAAA_5555 ^ 64'h8181_8181_8181_8181;
      eq = dbl(64'hAAAA_5555_AAAA_5555) ^ 64'h8181_8181_8181_8181;
      collect(ep, eq, "R10 pending");
      send(64'h0102_0304_0506_0708, 1'b0);
      send(64'h1000_0000_0000_0001, 1'b1);
      ep = 64'h0102_0304_0506_0708 ^ 64'h1000_0000_0000_0001;
      eq = dbl(64'h0102_0304_0506_0708) ^ 64'h1000_0000_0000_0001;
      collect(ep, eq, "R2/R10 next stripe");

      // R1: reset in mid stripe
      send(64'hdead_dead_dead_dead, 1'b0);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check(!res_valid && word_ready && res_p == '0 && res_q == '0, "R1 mid reset", res_p, 0);
      send(64'h0000_0000_0000_0003, 1'b0);
      send(64'h0000_0000_0000_0005, 1'b1);
      collect(64'h6, 64'h3, "R2 fresh after reset");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule